// File: doc/BRIEF.md
# Prioritized Transmit Buffer Scheduler

This block owns the life cycle of a small set of transmit buffers in a CAN-style controller. Each buffer has a 4-bit state field, and all fields are packed into one status word. Software-side command strobes select buffers with a bit mask. Each command can abort a pending buffer, mark a buffer ready, or release it back to empty. The frame payload storage and the serial transmitter sit outside the block. This block only decides which buffer goes next and tracks how each transfer ends.

While the core is enabled, the scheduler scans the ready buffers using a 3-bit priority per buffer and raises a transmit request carrying the winning index. It holds the request until the bus side returns a done pulse, with a failure flag beside it. A successful transfer marks the buffer transmitted-ok, bumps a frame counter and pulses two interrupt events. A failed transfer marks the buffer as error. The scan then repeats until no eligible buffer is left. A flag reports whether any buffer is still empty.

Top module: `txsched_top`

## Requirements
- R1: Buffer i keeps its state in `state_word[4i+3:4i]`, encoded empty=0, ready=1, ok=2, error=3, aborted=4. Synchronous reset puts every buffer in empty, clears `tx_cnt`, and leaves `tx_req` low.
- R2: An abort on a selected buffer changes ready to aborted and leaves every other state unchanged.
- R3: A set-ready on a selected buffer moves it to ready from empty, ok, error or aborted.
- R4: A set-empty on a selected buffer moves it to empty from ok, error or aborted, and leaves a ready buffer ready.
- R5: When several command bits are set in one write, they act one after another in the order abort, then set-ready, then set-empty. Bit i of `cmd_sel` selects buffer i, and selection bits at or above the buffer count are ignored.
- R6: While `core_en` is 0, buffer commands change no state and no transmission is started.
- R7: The priority of buffer i is `prio_word[4i+2:4i]`. A ready buffer wins only if its priority is strictly greater than the best value found so far, starting from 0. Ties go to the lowest index, and a ready buffer with priority 0 is never sent.
- R8: `tx_req` rises one cycle after a ready eligible buffer is seen. It stays high with `tx_idx` unchanged until `tx_done`, and drops in the cycle after `tx_done`.
- R9: A done pulse without `tx_fail` sets that buffer to ok and increments `tx_cnt`. It also raises `irq_tx` and `irq_bufcmd` together for exactly one cycle.
- R10: A done pulse with `tx_fail` sets that buffer to error, leaves `tx_cnt` unchanged and raises no interrupt event.
- R11: After each completion, scheduling starts again and continues until no ready buffer with nonzero priority remains.
- R12: `txnf` is 1 exactly when at least one buffer is in the empty state.
- R13: `cnt_clr` clears `tx_cnt` on the next edge and takes precedence over an increment in the same cycle.
- R14: Commands aimed at the buffer being transmitted are ignored, from the cycle the transfer is launched until its done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_en | input | 1 | Core enable; gates commands and new launches |
| cmd_valid | input | 1 | Command write strobe |
| cmd_sel | input | SEL_W | Buffer selection mask |
| cmd_abort | input | 1 | Abort operation |
| cmd_set_ready | input | 1 | Set-ready operation |
| cmd_set_empty | input | 1 | Set-empty operation |
| cnt_clr | input | 1 | Clear the transmit frame counter |
| prio_word | input | 4*NUM_BUF | Per-buffer priority fields |
| tx_req | output | 1 | Transmit request to the bus side |
| tx_idx | output | IDX_W | Index of the buffer being sent |
| tx_done | input | 1 | Transfer finished pulse |
| tx_fail | input | 1 | Transfer failed, valid with tx_done |
| state_word | output | 4*NUM_BUF | Packed buffer states |
| txnf | output | 1 | At least one buffer is empty |
| tx_cnt | output | CNT_W | Successful transmit counter |
| irq_tx | output | 1 | Transmit-done interrupt event |
| irq_bufcmd | output | 1 | Buffer-state interrupt event |

## Verification
Two cases are the hardest to reach from the ports. The first is a command that hits the in-flight buffer while its request is pending. The second is a counter clear that lands in the same cycle as a successful completion. The stimulus sets up each one by raising a single buffer's priority, waiting for `tx_req`, and then holding back `tx_done` while it issues an abort-plus-empty command to that buffer, or while it raises `cnt_clr` together with the done pulse. The transmitted-ok and error start states can only be reached through a real transfer. The table walk therefore first drives each buffer through a served request, with and without `tx_fail`, before it applies the command under test.

// File: rtl/txsched_pkg.sv
package txsched_pkg;

    localparam int FIELD_W = 4;

    typedef enum logic [FIELD_W-1:0] {
        ST_EMPTY = 4'd0,
        ST_READY = 4'd1,
        ST_OK    = 4'd2,
        ST_ERR   = 4'd3,
        ST_ABORT = 4'd4
    } buf_st_e;

    typedef enum logic {
        SCH_IDLE = 1'b0,
        SCH_BUSY = 1'b1
    } sched_st_e;

    typedef struct packed {
        logic do_abort;
        logic do_ready;
        logic do_empty;
    } cmd_ops_t;

    // Apply the three operations in their fixed order to one buffer state.
    function automatic logic [FIELD_W-1:0] step_state(input logic [FIELD_W-1:0] cur,
                                                      input cmd_ops_t op);
        logic [FIELD_W-1:0] s;
        s = cur;
        if (op.do_abort && s == ST_READY)
            s = ST_ABORT;
        if (op.do_ready && (s == ST_EMPTY || s == ST_OK || s == ST_ERR || s == ST_ABORT))
            s = ST_READY;
        if (op.do_empty && (s == ST_OK || s == ST_ERR || s == ST_ABORT))
            s = ST_EMPTY;
        return s;
    endfunction

endpackage

// File: rtl/txsched_cmd_unit.sv
module txsched_cmd_unit
    import txsched_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int SEL_W   = 8,
    parameter int IDX_W   = 2
) (
    input  logic                       core_en,
    input  logic                       cmd_valid,
    input  logic [SEL_W-1:0]           cmd_sel,
    input  cmd_ops_t                   cmd_op,
    input  logic                       lock_valid,
    input  logic [IDX_W-1:0]           lock_idx,
    input  logic [NUM_BUF*FIELD_W-1:0] cur_word,
    output logic [NUM_BUF*FIELD_W-1:0] nxt_word
);

    localparam int USED_SEL = (SEL_W < NUM_BUF) ? SEL_W : NUM_BUF;

    for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
        logic hit;
        logic [FIELD_W-1:0] cur_f;
        if (g < USED_SEL) begin : g_sel
            assign hit = cmd_valid && core_en && cmd_sel[g]
                         && !(lock_valid && lock_idx == IDX_W'(g));
        end else begin : g_nosel
            assign hit = 1'b0;
        end
        assign cur_f = cur_word[g*FIELD_W +: FIELD_W];
        assign nxt_word[g*FIELD_W +: FIELD_W] = hit ? step_state(cur_f, cmd_op) : cur_f;
    end

    if (SEL_W > NUM_BUF) begin : g_spare
        logic spare_sel_unused;
        assign spare_sel_unused = ^cmd_sel[SEL_W-1:NUM_BUF];
    end

endmodule

// File: rtl/txsched_picker.sv
module txsched_picker
    import txsched_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int PRIO_W  = 3,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_BUF*FIELD_W-1:0] state_word,
    input  logic [NUM_BUF*FIELD_W-1:0] prio_word,
    output logic                       found,
    output logic [IDX_W-1:0]           pick_idx
);

    localparam logic [FIELD_W-1:0] PMASK = FIELD_W'((1 << PRIO_W) - 1);

    always_comb begin
        logic [FIELD_W-1:0] best;
        logic [FIELD_W-1:0] pv;
        best     = '0;
        found    = 1'b0;
        pick_idx = '0;
        for (int i = 0; i < NUM_BUF; i++) begin
            pv = prio_word[i*FIELD_W +: FIELD_W] & PMASK;
            if (state_word[i*FIELD_W +: FIELD_W] == ST_READY && pv > best) begin
                best     = pv;
                pick_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/txsched_top.sv
module txsched_top
    import txsched_pkg::*;
#(
    parameter int NUM_BUF = 4,
    parameter int SEL_W   = 8,
    parameter int PRIO_W  = 3,
    parameter int CNT_W   = 32,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int WORD_W = NUM_BUF * 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              core_en,
    input  logic              cmd_valid,
    input  logic [SEL_W-1:0]  cmd_sel,
    input  logic              cmd_abort,
    input  logic              cmd_set_ready,
    input  logic              cmd_set_empty,
    input  logic              cnt_clr,
    input  logic [WORD_W-1:0] prio_word,
    output logic              tx_req,
    output logic [IDX_W-1:0]  tx_idx,
    input  logic              tx_done,
    input  logic              tx_fail,
    output logic [WORD_W-1:0] state_word,
    output logic              txnf,
    output logic [CNT_W-1:0]  tx_cnt,
    output logic              irq_tx,
    output logic              irq_bufcmd
);

    sched_st_e          fsm_q, fsm_d;
    logic [IDX_W-1:0]   idx_q, idx_d;
    logic [WORD_W-1:0]  st_q, st_d, cmd_next;
    logic [CNT_W-1:0]   cnt_q, cnt_d;
    logic               ev_q, ev_d;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic               launch;
    logic               lock_valid;
    logic [IDX_W-1:0]   lock_idx;
    cmd_ops_t           op;

    assign op.do_abort = cmd_abort;
    assign op.do_ready = cmd_set_ready;
    assign op.do_empty = cmd_set_empty;

    txsched_picker #(
        .NUM_BUF (NUM_BUF),
        .PRIO_W  (PRIO_W),
        .IDX_W   (IDX_W)
    ) u_pick (
        .state_word (st_q),
        .prio_word  (prio_word),
        .found      (pick_found),
        .pick_idx   (pick_idx)
    );

    assign launch     = (fsm_q == SCH_IDLE) && core_en && pick_found;
    assign lock_valid = (fsm_q == SCH_BUSY) || launch;
    assign lock_idx   = (fsm_q == SCH_BUSY) ? idx_q : pick_idx;

    txsched_cmd_unit #(
        .NUM_BUF (NUM_BUF),
        .SEL_W   (SEL_W),
        .IDX_W   (IDX_W)
    ) u_cmd (
        .core_en    (core_en),
        .cmd_valid  (cmd_valid),
        .cmd_sel    (cmd_sel),
        .cmd_op     (op),
        .lock_valid (lock_valid),
        .lock_idx   (lock_idx),
        .cur_word   (st_q),
        .nxt_word   (cmd_next)
    );

    always_comb begin
        st_d  = cmd_next;
        fsm_d = fsm_q;
        idx_d = idx_q;
        ev_d  = 1'b0;
        case (fsm_q)
            SCH_IDLE: begin
                if (launch) begin
                    fsm_d = SCH_BUSY;
                    idx_d = pick_idx;
                end
            end
            SCH_BUSY: begin
                if (tx_done) begin
                    st_d[idx_q*FIELD_W +: FIELD_W] = tx_fail ? ST_ERR : ST_OK;
                    fsm_d = SCH_IDLE;
                    ev_d  = !tx_fail;
                end
            end
            default: fsm_d = SCH_IDLE;
        endcase
    end

    always_comb begin
        if (cnt_clr)
            cnt_d = '0;
        else if (ev_d)
            cnt_d = cnt_q + CNT_W'(1);
        else
            cnt_d = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fsm_q <= SCH_IDLE;
            idx_q <= '0;
            st_q  <= {NUM_BUF{ST_EMPTY}};
            cnt_q <= '0;
            ev_q  <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
            idx_q <= idx_d;
            st_q  <= st_d;
            cnt_q <= cnt_d;
            ev_q  <= ev_d;
        end
    end

    always_comb begin
        txnf = 1'b0;
        for (int i = 0; i < NUM_BUF; i++)
            if (st_q[i*FIELD_W +: FIELD_W] == ST_EMPTY)
                txnf = 1'b1;
    end

    assign tx_req     = (fsm_q == SCH_BUSY);
    assign tx_idx     = idx_q;
    assign state_word = st_q;
    assign tx_cnt     = cnt_q;
    assign irq_tx     = ev_q;
    assign irq_bufcmd = ev_q;

endmodule

// File: rtl/txsched_checker.sv
module txsched_checker #(
    parameter int NUM_BUF = 4,
    parameter int PRIO_W  = 3,
    parameter int CNT_W   = 32,
    localparam int IDX_W  = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
    localparam int WORD_W = NUM_BUF * 4
) (
    input logic              clk,
    input logic              rst,
    input logic              core_en,
    input logic              cnt_clr,
    input logic [WORD_W-1:0] prio_word,
    input logic              tx_req,
    input logic [IDX_W-1:0]  tx_idx,
    input logic              tx_done,
    input logic              tx_fail,
    input logic [WORD_W-1:0] state_word,
    input logic              txnf,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic              irq_tx,
    input logic              irq_bufcmd
);

    localparam logic [3:0] PMASK = 4'((1 << PRIO_W) - 1);

    logic [IDX_W-1:0]  idx_d;
    logic [WORD_W-1:0] prio_d;

    always_ff @(posedge clk) begin
        idx_d  <= tx_idx;
        prio_d <= prio_word;
    end

    p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (state_word == '0 && txnf && !tx_req && tx_cnt == '0));

    p_no_start_off_r6: assert property (@(posedge clk) disable iff (rst)
        (!core_en && !tx_req) |=> !tx_req);

    p_prio_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_req) |-> ((prio_d[tx_idx*4 +: 4] & PMASK) != 4'd0));

    p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_req && !tx_done) |=> (tx_req && $stable(tx_idx)));

    p_req_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_done) |=> !tx_req);

    p_ok_mark_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_done && !tx_fail) |=>
            (state_word[idx_d*4 +: 4] == 4'd2 && irq_tx && irq_bufcmd));

    p_irq_source_r9: assert property (@(posedge clk) disable iff (rst)
        (irq_tx || irq_bufcmd) |-> $past(tx_req && tx_done && !tx_fail));

    p_count_step_r9: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_done && !tx_fail && !cnt_clr) |=> (tx_cnt == $past(tx_cnt) + CNT_W'(1)));

    p_err_mark_r10: assert property (@(posedge clk) disable iff (rst)
        (tx_req && tx_done && tx_fail) |=>
            (state_word[idx_d*4 +: 4] == 4'd3 && !irq_tx && $stable(tx_cnt)));

    p_count_clear_r13: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (tx_cnt == '0));

endmodule

bind txsched_top txsched_checker #(
    .NUM_BUF (NUM_BUF),
    .PRIO_W  (PRIO_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .core_en    (core_en),
    .cnt_clr    (cnt_clr),
    .prio_word  (prio_word),
    .tx_req     (tx_req),
    .tx_idx     (tx_idx),
    .tx_done    (tx_done),
    .tx_fail    (tx_fail),
    .state_word (state_word),
    .txnf       (txnf),
    .tx_cnt     (tx_cnt),
    .irq_tx     (irq_tx),
    .irq_bufcmd (irq_bufcmd)
);

// File: tb/tb_txsched_top.sv
module tb_txsched_top;

    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int SW = 8;
    localparam int PW = 3;
    localparam int CW = 32;
    localparam int IW = 2;
    localparam int WW = NB * 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          core_en = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [SW-1:0] cmd_sel = '0;
    logic          cmd_abort = 1'b0;
    logic          cmd_set_ready = 1'b0;
    logic          cmd_set_empty = 1'b0;
    logic          cnt_clr = 1'b0;
    logic [WW-1:0] prio_word = '0;
    logic          tx_req;
    logic [IW-1:0] tx_idx;
    logic          tx_done = 1'b0;
    logic          tx_fail = 1'b0;
    logic [WW-1:0] state_word;
    logic          txnf;
    logic [CW-1:0] tx_cnt;
    logic          irq_tx;
    logic          irq_bufcmd;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    txsched_top #(
        .NUM_BUF (NB),
        .SEL_W   (SW),
        .PRIO_W  (PW),
        .CNT_W   (CW)
    ) dut (
        .clk           (clk),
        .rst           (rst),
        .core_en       (core_en),
        .cmd_valid     (cmd_valid),
        .cmd_sel       (cmd_sel),
        .cmd_abort     (cmd_abort),
        .cmd_set_ready (cmd_set_ready),
        .cmd_set_empty (cmd_set_empty),
        .cnt_clr       (cnt_clr),
        .prio_word     (prio_word),
        .tx_req        (tx_req),
        .tx_idx        (tx_idx),
        .tx_done       (tx_done),
        .tx_fail       (tx_fail),
        .state_word    (state_word),
        .txnf          (txnf),
        .tx_cnt        (tx_cnt),
        .irq_tx        (irq_tx),
        .irq_bufcmd    (irq_bufcmd)
    );

    // {start state, abort, set-ready, set-empty, expected state}
    localparam int NV = 19;
    localparam logic [10:0] VEC_TAB [NV] = '{
        {4'd0, 3'b100, 4'd0}, {4'd0, 3'b010, 4'd1}, {4'd0, 3'b001, 4'd0},
        {4'd1, 3'b100, 4'd4}, {4'd1, 3'b010, 4'd1}, {4'd1, 3'b001, 4'd1},
        {4'd2, 3'b100, 4'd2}, {4'd2, 3'b010, 4'd1}, {4'd2, 3'b001, 4'd0},
        {4'd3, 3'b100, 4'd3}, {4'd3, 3'b010, 4'd1}, {4'd3, 3'b001, 4'd0},
        {4'd4, 3'b100, 4'd4}, {4'd4, 3'b010, 4'd1}, {4'd4, 3'b001, 4'd0},
        {4'd1, 3'b110, 4'd1}, {4'd1, 3'b101, 4'd0}, {4'd2, 3'b011, 4'd1},
        {4'd4, 3'b111, 4'd1}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [3:0] fld(input logic [WW-1:0] w, input int b);
        return w[b*4 +: 4];
    endfunction

    task automatic drive_cmd(input logic [SW-1:0] sel, input logic a, input logic r, input logic e);
        cmd_sel = sel; cmd_abort = a; cmd_set_ready = r; cmd_set_empty = e; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_abort = 1'b0; cmd_set_ready = 1'b0; cmd_set_empty = 1'b0; cmd_sel = '0;
    endtask

    task automatic wait_req(output logic seen);
        int k;
        k = 0;
        while (!tx_req && k < 40) begin
            @(negedge clk);
            k++;
        end
        seen = tx_req;
    endtask

    task automatic serve(input logic fail, output logic [IW-1:0] got, output logic seen);
        got = '0;
        wait_req(seen);
        if (seen) begin
            got = tx_idx;
            tx_done = 1'b1; tx_fail = fail;
            @(negedge clk);
            tx_done = 1'b0; tx_fail = 1'b0;
        end
    endtask

    task automatic go_state(input logic [3:0] st);
        logic [IW-1:0] g;
        logic s;
        drive_cmd(8'h04, 1'b1, 1'b0, 1'b1);
        case (st)
            4'd1: drive_cmd(8'h04, 1'b0, 1'b1, 1'b0);
            4'd4: begin
                drive_cmd(8'h04, 1'b0, 1'b1, 1'b0);
                drive_cmd(8'h04, 1'b1, 1'b0, 1'b0);
            end
            4'd2, 4'd3: begin
                prio_word = 16'h0100;
                drive_cmd(8'h04, 1'b0, 1'b1, 1'b0);
                serve(st == 4'd3, g, s);
                chk("R8 setup request seen", {31'd0, s}, 32'd1);
                prio_word = '0;
            end
            default: ;
        endcase
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [IW-1:0] got;
        logic seen;
        logic [10:0] ent;
        logic [WW-1:0] snap;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset state word", 32'(state_word), 32'd0);
        chk("R1 reset tx_req", {31'd0, tx_req}, 32'd0);
        chk("R1 reset tx_cnt", tx_cnt, 32'd0);
        chk("R12 txnf after reset", {31'd0, txnf}, 32'd1);

        // Table walk on buffer 2, priorities all zero (R2 R3 R4 R5)
        core_en = 1'b1;
        for (int v = 0; v < NV; v++) begin
            ent = VEC_TAB[v];
            go_state(ent[10:7]);
            chk("R1 table start state", 32'(fld(state_word, 2)), 32'(ent[10:7]));
            drive_cmd(8'h04, ent[6], ent[5], ent[4]);
            chk("R2 R3 R4 R5 table result", 32'(fld(state_word, 2)), 32'(ent[3:0]));
        end

        // R13: clear counter
        drive_cmd(8'h0F, 1'b1, 1'b0, 1'b1);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        chk("R13 counter cleared", tx_cnt, 32'd0);

        // R5: selection bits above the buffer count
        snap = state_word;
        drive_cmd(8'hF0, 1'b0, 1'b1, 1'b0);
        chk("R5 high select bits ignored", 32'(state_word), 32'(snap));

        // R6: disabled core
        core_en = 1'b0;
        drive_cmd(8'h01, 1'b0, 1'b1, 1'b0);
        chk("R6 command ignored when disabled", 32'(fld(state_word, 0)), 32'd0);
        core_en = 1'b1;
        drive_cmd(8'h01, 1'b0, 1'b1, 1'b0);
        core_en = 1'b0;
        prio_word = 16'h0007;
        repeat (3) @(negedge clk);
        chk("R6 no launch when disabled", {31'd0, tx_req}, 32'd0);
        core_en = 1'b1;
        serve(1'b0, got, seen);
        chk("R6 launch after enable", {31'd0, seen}, 32'd1);
        chk("R9 buffer 0 ok", 32'(fld(state_word, 0)), 32'd2);
        chk("R9 counter one", tx_cnt, 32'd1);

        // R7 R11: priorities b0=2, b1=5, b2=5, b3=0
        prio_word = 16'h0552;
        drive_cmd(8'h0F, 1'b0, 1'b1, 1'b0);
        serve(1'b0, got, seen);
        chk("R7 tie goes to lowest index", 32'(got), 32'd1);
        chk("R9 irq_tx pulse", {31'd0, irq_tx}, 32'd1);
        chk("R9 irq_bufcmd pulse", {31'd0, irq_bufcmd}, 32'd1);
        @(negedge clk);
        chk("R9 irq_tx single cycle", {31'd0, irq_tx}, 32'd0);
        serve(1'b0, got, seen);
        chk("R11 second pick", 32'(got), 32'd2);
        serve(1'b0, got, seen);
        chk("R7 lower priority last", 32'(got), 32'd0);
        repeat (5) @(negedge clk);
        chk("R7 zero priority never sent", {31'd0, tx_req}, 32'd0);
        chk("R7 zero priority stays ready", 32'(fld(state_word, 3)), 32'd1);
        chk("R11 counter after sweep", tx_cnt, 32'd4);
        chk("R12 txnf low when none empty", {31'd0, txnf}, 32'd0);
        drive_cmd(8'h01, 1'b0, 1'b0, 1'b1);
        chk("R12 txnf high after release", {31'd0, txnf}, 32'd1);

        // R8 R14 R10: hold request, command to in-flight buffer, failure
        prio_word = 16'h0030;
        drive_cmd(8'h02, 1'b0, 1'b1, 1'b0);
        wait_req(seen);
        for (int k = 0; k < 4; k++) begin
            chk("R8 request held", {31'd0, tx_req}, 32'd1);
            chk("R8 index held", 32'(tx_idx), 32'd1);
            @(negedge clk);
        end
        drive_cmd(8'h02, 1'b1, 1'b0, 1'b1);
        chk("R14 in-flight buffer untouched", 32'(fld(state_word, 1)), 32'd1);
        serve(1'b1, got, seen);
        chk("R10 buffer error", 32'(fld(state_word, 1)), 32'd3);
        chk("R10 counter unchanged", tx_cnt, 32'd4);
        chk("R10 no irq", {30'd0, irq_tx, irq_bufcmd}, 32'd0);
        chk("R8 request dropped", {31'd0, tx_req}, 32'd0);

        // R13: clear wins over increment
        drive_cmd(8'h02, 1'b0, 1'b1, 1'b0);
        wait_req(seen);
        tx_done = 1'b1; cnt_clr = 1'b1;
        @(negedge clk);
        tx_done = 1'b0; cnt_clr = 1'b0;
        chk("R13 clear beats increment", tx_cnt, 32'd0);
        chk("R9 buffer 1 ok", 32'(fld(state_word, 1)), 32'd2);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule